// File: doc/BRIEF.md
# Configurable Two-Level Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It is meant for a 32-bit in-order pipeline with two fetch stages, where the branch condition is only known in the execute stage. The fetch side presents a PC and receives a one-bit taken/not-taken guess in the same cycle. Later, the execute stage presents the PC of the resolved branch together with its real outcome, and the block trains its history and counters with it.

A compile-time parameter selects one of four schemes. In the bimodal scheme the PC picks a counter directly. In the GAg scheme a single global outcome history picks a counter. The gshare scheme XORs that global history with the PC. In the PAg scheme the PC picks a private history from a first-level table, and that history picks a counter in a pattern table shared by all branches. The first-level history table and the second-level pattern table are sized separately, each between 64 and 4096 entries, and each size must be a power of two. Target prediction and pipeline flush or stall control are handled elsewhere.

Top module: `dir_predictor`

## Requirements
- R1: After reset every pattern counter holds 2'b01 (weakly not taken) and every history register is zero, so every lookup returns not taken.
- R2: Each pattern entry is a 2-bit counter. A taken update adds one and a not-taken update subtracts one. `lkp_taken` is 1 exactly when the selected counter is 2 or 3.
- R3: A counter saturates: a taken update leaves 3 at 3, and a not-taken update leaves 0 at 0.
- R4: Bimodal scheme: the pattern index is PC bits [P+1:2], where P = log2(PHT_ENTRIES).
- R5: GAg scheme: the pattern index is the global history register alone.
- R6: Gshare scheme: the pattern index is PC bits [P+1:2] XOR the global history register.
- R7: PAg scheme: PC bits [B+1:2], where B = log2(BHT_ENTRIES), select a private history entry, and that history is the index into the shared pattern table.
- R8: A history register is P bits wide. Each valid update shifts it left and puts the resolved outcome in bit 0. The update is applied to the global register or to the PAg entry selected by `upd_pc`.
- R9: When `upd_valid` is low, no counter and no history changes, whatever `upd_pc` and `upd_taken` hold.
- R10: A lookup and an update in the same cycle see the state from before the clock edge. A lookup that hits the entry being updated returns the old prediction, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | 32 | PC of the instruction being fetched |
| lkp_taken | output | 1 | Combinational direction guess for `lkp_pc` |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The hardest state to reach from the ports is a history-indexed pattern entry driven to saturation while other branches keep moving the history. In the GAg, gshare and PAg schemes the counter a branch trains depends on the outcomes that came before it. The bench therefore draws its random traffic from a small pool of PCs, each with its own taken bias, so that the same histories recur and counters reach both limits. Four instances, one for each scheme, receive the same stimulus and are compared every cycle with a bench model. Directed sequences cover the reset state, saturation at both ends, a lookup that collides with an update, and long stretches with the update strobe low.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    SCH_BIMODAL = 2'd0,
    SCH_GAG     = 2'd1,
    SCH_GSHARE  = 2'd2,
    SCH_PAG     = 2'd3
  } scheme_e;

  localparam int unsigned MAXW = 16;

  // Two-bit saturating step toward the resolved outcome.
  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic t);
    logic [1:0] r;
    if (t) r = (c == 2'd3) ? 2'd3 : c + 2'd1;
    else   r = (c == 2'd0) ? 2'd0 : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_taken(input logic [1:0] c);
    return c[1];
  endfunction

  // Shift the outcome into bit 0; caller truncates to its width.
  function automatic logic [MAXW-1:0] hist_push(input logic [MAXW-1:0] h, input logic t);
    return {h[MAXW-2:0], t};
  endfunction

  // Pattern index selection per scheme; caller truncates to its width.
  function automatic logic [MAXW-1:0] pick_index(input scheme_e s,
                                                 input logic [MAXW-1:0] pcb,
                                                 input logic [MAXW-1:0] h);
    logic [MAXW-1:0] r;
    case (s)
      SCH_BIMODAL: r = pcb;
      SCH_GSHARE:  r = pcb ^ h;
      default:     r = h;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index
  import bp_pkg::*;
#(
  parameter scheme_e     SCHEME = SCH_GSHARE,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [IDX_W-1:0] pc_bits,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  logic [MAXW-1:0] pc_ext;
  logic [MAXW-1:0] hist_ext;
  logic [MAXW-1:0] idx_ext;
  logic            unused_idx_hi;

  always_comb begin
    pc_ext              = '0;
    hist_ext            = '0;
    pc_ext[IDX_W-1:0]   = pc_bits;
    hist_ext[IDX_W-1:0] = hist;
    idx_ext             = pick_index(SCHEME, pc_ext, hist_ext);
  end

  assign idx           = idx_ext[IDX_W-1:0];
  assign unused_idx_hi = ^idx_ext[MAXW-1:IDX_W];
endmodule

// File: rtl/bp_history.sv
module bp_history
  import bp_pkg::*;
#(
  parameter scheme_e     SCHEME      = SCH_GSHARE,
  parameter int unsigned BHT_ENTRIES = 1024,
  parameter int unsigned HIST_W      = 10,
  localparam int unsigned BIDX_W     = $clog2(BHT_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BIDX_W-1:0] lkp_bidx,
  input  logic [BIDX_W-1:0] upd_bidx,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] lkp_hist,
  output logic [HIST_W-1:0] upd_hist,
  output logic [HIST_W-1:0] glob_hist
);
  logic [MAXW-1:0] push_in;
  logic [MAXW-1:0] push_out;
  logic            unused_push_hi;

  always_comb begin
    push_in             = '0;
    push_in[HIST_W-1:0] = upd_hist;
    push_out            = hist_push(push_in, upd_taken);
  end
  assign unused_push_hi = ^push_out[MAXW-1:HIST_W];

  generate
    if (SCHEME == SCH_PAG) begin : g_private
      logic [HIST_W-1:0] bht_q [BHT_ENTRIES];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < BHT_ENTRIES; i++) bht_q[i] <= '0;
        end else if (upd_en) begin
          bht_q[upd_bidx] <= push_out[HIST_W-1:0];
        end
      end

      assign lkp_hist  = bht_q[lkp_bidx];
      assign upd_hist  = bht_q[upd_bidx];
      assign glob_hist = '0;
    end else begin : g_global
      logic [HIST_W-1:0] ghr_q;
      logic              unused_bidx;

      always_ff @(posedge clk) begin
        if (!rst_n)      ghr_q <= '0;
        else if (upd_en) ghr_q <= push_out[HIST_W-1:0];
      end

      assign lkp_hist    = ghr_q;
      assign upd_hist    = ghr_q;
      assign glob_hist   = ghr_q;
      assign unused_bidx = ^{lkp_bidx, upd_bidx};
    end
  endgenerate
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [1:0]       wr_old,
  output logic [1:0]       wr_new
);
  logic [1:0] ctr_q [ENTRIES];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_next(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/dir_predictor.sv
module dir_predictor
  import bp_pkg::*;
#(
  parameter scheme_e     SCHEME      = SCH_GSHARE,
  parameter int unsigned PHT_ENTRIES = 1024,
  parameter int unsigned BHT_ENTRIES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] lkp_pc,
  output logic        lkp_taken,
  input  logic        upd_valid,
  input  logic [31:0] upd_pc,
  input  logic        upd_taken
);
  localparam int unsigned IDX_W  = $clog2(PHT_ENTRIES);
  localparam int unsigned BIDX_W = $clog2(BHT_ENTRIES);
  localparam int unsigned HIST_W = IDX_W;
  localparam int unsigned TOP_W  = (IDX_W > BIDX_W) ? IDX_W : BIDX_W;

  // Named internal events, observed by the bound checker.
  logic [IDX_W-1:0]  lkp_idx;
  logic [IDX_W-1:0]  upd_idx;
  logic [1:0]        lkp_ctr;
  logic [1:0]        upd_ctr_old;
  logic [1:0]        upd_ctr_new;
  logic [HIST_W-1:0] lkp_hist;
  logic [HIST_W-1:0] upd_hist;
  logic [HIST_W-1:0] hist_glob;
  logic              unused_pc;

  assign unused_pc = ^{lkp_pc[31:TOP_W+2], lkp_pc[1:0],
                       upd_pc[31:TOP_W+2], upd_pc[1:0]};

  bp_history #(
    .SCHEME(SCHEME), .BHT_ENTRIES(BHT_ENTRIES), .HIST_W(HIST_W)
  ) u_hist (
    .clk(clk), .rst_n(rst_n),
    .lkp_bidx(lkp_pc[BIDX_W+1:2]), .upd_bidx(upd_pc[BIDX_W+1:2]),
    .upd_en(upd_valid), .upd_taken(upd_taken),
    .lkp_hist(lkp_hist), .upd_hist(upd_hist), .glob_hist(hist_glob)
  );

  bp_index #(.SCHEME(SCHEME), .IDX_W(IDX_W)) u_lkp_idx (
    .pc_bits(lkp_pc[IDX_W+1:2]), .hist(lkp_hist), .idx(lkp_idx)
  );

  bp_index #(.SCHEME(SCHEME), .IDX_W(IDX_W)) u_upd_idx (
    .pc_bits(upd_pc[IDX_W+1:2]), .hist(upd_hist), .idx(upd_idx)
  );

  bp_counter_table #(.ENTRIES(PHT_ENTRIES)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lkp_idx), .rd_ctr(lkp_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
    .wr_old(upd_ctr_old), .wr_new(upd_ctr_new)
  );

  assign lkp_taken = ctr_taken(lkp_ctr);
endmodule

// File: rtl/dir_predictor_chk.sv
module dir_predictor_chk #(
  parameter int unsigned HIST_W = 10,
  parameter bit          GLOBAL = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist_glob,
  input logic [1:0]        upd_ctr_old,
  input logic [1:0]        upd_ctr_new
);
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist_glob)); // R9

  AST_HIST_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (GLOBAL && upd_valid) |=> hist_glob[0] == $past(upd_taken)); // R8

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (GLOBAL && upd_valid) |=> hist_glob[HIST_W-1:1] == $past(hist_glob[HIST_W-2:0])); // R8

  AST_CTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |-> upd_ctr_new >= upd_ctr_old); // R2

  AST_CTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |-> upd_ctr_new <= upd_ctr_old); // R2

  AST_CTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_ctr_old == {2{upd_taken}})) |-> upd_ctr_new == upd_ctr_old); // R3
endmodule

bind dir_predictor dir_predictor_chk #(
  .HIST_W(HIST_W), .GLOBAL(SCHEME != bp_pkg::SCH_PAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .hist_glob(hist_glob), .upd_ctr_old(upd_ctr_old), .upd_ctr_new(upd_ctr_new)
);

// File: tb/dir_predictor_tb_top.sv
module dir_predictor_tb_top;
  import bp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [3:0]  pred_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // index 0 bimodal/128, 1 GAg/64, 2 gshare/1024, 3 PAg 64 x 512
  dir_predictor #(.SCHEME(SCH_BIMODAL), .PHT_ENTRIES(128), .BHT_ENTRIES(64)) dut_bim (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(pred_w[0]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  dir_predictor #(.SCHEME(SCH_GAG), .PHT_ENTRIES(64), .BHT_ENTRIES(64)) dut_gag (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(pred_w[1]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  dir_predictor #(.SCHEME(SCH_GSHARE), .PHT_ENTRIES(1024), .BHT_ENTRIES(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(pred_w[2]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));
  dir_predictor #(.SCHEME(SCH_PAG), .PHT_ENTRIES(512), .BHT_ENTRIES(64)) dut_pag (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(pred_w[3]),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // Independent reference model.
  int    idxw [4] = '{7, 6, 10, 9};
  int    bhtw = 6;
  string rq [4] = '{"R4", "R5 R8", "R6 R8", "R7 R8"};
  int    pht [4][4096];
  int    ghr [4];
  int    bhr [4][64];

  function automatic void model_reset();
    for (int s = 0; s < 4; s++) begin
      ghr[s] = 0;
      for (int i = 0; i < 4096; i++) pht[s][i] = 1;
      for (int i = 0; i < 64; i++) bhr[s][i] = 0;
    end
  endfunction

  function automatic int model_idx(int s, logic [31:0] pc);
    int m   = (1 << idxw[s]) - 1;
    int pcb = int'(pc >> 2) & m;
    int bi  = int'(pc >> 2) & ((1 << bhtw) - 1);
    case (s)
      0:       return pcb;
      1:       return ghr[s];
      2:       return pcb ^ ghr[s];
      default: return bhr[s][bi];
    endcase
  endfunction

  function automatic bit model_pred(int s, logic [31:0] pc);
    return pht[s][model_idx(s, pc)] >= 2;
  endfunction

  function automatic void model_update(logic [31:0] pc, bit t);
    for (int s = 0; s < 4; s++) begin
      int i  = model_idx(s, pc);
      int m  = (1 << idxw[s]) - 1;
      int bi = int'(pc >> 2) & ((1 << bhtw) - 1);
      if (t && pht[s][i] < 3) pht[s][i]++;
      if (!t && pht[s][i] > 0) pht[s][i]--;
      if (s == 3) bhr[s][bi] = ((bhr[s][bi] << 1) | int'(t)) & m;
      else        ghr[s] = ((ghr[s] << 1) | int'(t)) & m;
    end
  endfunction

  task automatic chk(string req, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pc %h got %0b exp %0b", req, lkp_pc, got, exp);
    end
  endtask

  logic [3:0] snap;

  // One cycle: drive at negedge, compare all schemes, model the edge.
  task automatic step(string tag, logic [31:0] lpc, bit uv, logic [31:0] upc, bit ut);
    @(negedge clk);
    lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    snap = pred_w;
    for (int s = 0; s < 4; s++)
      chk({tag, " ", rq[s]}, pred_w[s], model_pred(s, lpc));
    if (uv) model_update(upc, ut);
  endtask

  logic [31:0] pool [16];
  int          bias [16];

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all not taken after reset
    for (int k = 0; k < 20; k++) begin
      step("R1", $urandom & 32'hFFFC, 1'b0, $urandom, 1'b1);
      chk("R1", |snap, 1'b0);
    end

    // R10: colliding lookup sees old counter (bimodal entry of 0x100)
    step("R10", 32'h100, 1'b1, 32'h100, 1'b1);
    chk("R10", snap[0], 1'b0);
    step("R2", 32'h100, 1'b0, 32'h0, 1'b0);
    chk("R2", snap[0], 1'b1);
    for (int k = 0; k < 4; k++) step("R3", 32'h200, 1'b1, 32'h100, 1'b1);
    step("R3", 32'h100, 1'b1, 32'h100, 1'b0);
    chk("R3", snap[0], 1'b1);
    step("R3", 32'h100, 1'b0, 32'h0, 1'b0);
    chk("R3", snap[0], 1'b1);
    for (int k = 0; k < 5; k++) step("R2", 32'h200, 1'b1, 32'h100, 1'b0);
    step("R3", 32'h100, 1'b1, 32'h100, 1'b1);
    chk("R3", snap[0], 1'b0);
    step("R3", 32'h100, 1'b0, 32'h0, 1'b0);
    chk("R3", snap[0], 1'b0);

    // Random traffic over a small, biased PC pool
    for (int k = 0; k < 16; k++) begin
      pool[k] = 32'h0040_0000 + k * 32'h54;
      bias[k] = k * 6 + 5;
    end
    for (int n = 0; n < 3000; n++) begin
      int a = $urandom % 16;
      int b = $urandom % 16;
      bit t = ($urandom % 100) < bias[b];
      step("rand", pool[a], ($urandom % 4) != 0, pool[b], t);
    end

    // R9: strobe low, inputs toggling, nothing may move
    for (int n = 0; n < 300; n++) begin
      int a = $urandom % 16;
      step("R9", pool[a], 1'b0, pool[$urandom % 16], $urandom % 2);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule